// File: doc/BRIEF.md
# Address Table Flush-Move Engine

This block holds a small table of learned station addresses for an Ethernet switch and an engine that runs host-issued operations on it. The host fills a set of staging registers (station address, entry data and a database number) and then writes an operation code. The operation can load or purge one entry, fetch the next entry in address order, or flush or move a group of entries. While the operation runs, a busy flag stays high.

The table has sixteen slots. Every operation visits them one per cycle, so no hashing or content-addressed lookup is needed. Flush and move share one path, and the action is chosen by the entry-state field of the data register. A state of zero invalidates every selected entry. A state of all ones moves the selected entries from one port to another. When the destination is the reserved all-ones port code, the move removes the entry from the source port instead.

Top module: `atu_flush_move`

## Requirements
- R1: After reset, busy reads 0, the data and address registers read 0, and the table is empty: a get-next from any start returns entry state 0.
- R2: Register offsets are: 0 operation, 1 data, 2 to 4 station address. Writing offset 0 with a code from 1 to 6 in bits 14:12 starts an operation, and bit 15 of offset 0 then reads 1 until the operation ends, at most DEPTH+3 cycles later. Code 0 or 7 starts nothing. While busy is set, writes to any register are ignored, and bits 14:0 of offset 0 read back the last accepted operation word.
- R3: The data register holds the entry state in bits 3:0, the port vector in bits 10:4 and the trunk flag in bit 15. The address registers at offsets 2, 3 and 4 hold bytes 0-1, 2-3 and 4-5, with the lower-numbered byte in bits 15:8. Byte 0 is the most significant byte for ordering.
- R4: Load/purge (code 3) with a nonzero state either overwrites the entry that has the same address and database, or places the new entry in a free slot. With state 0 it removes that entry.
- R5: Get-next (code 4) returns the valid entry of the selected database with the smallest address above the start address, and writes its address and data into the registers. If no such entry exists, it returns state 0 and an all-ones address.
- R6: A get-next that starts from the all-ones address wraps around and returns the lowest address in the database.
- R7: Flush/move codes are 1 (all entries, every database), 2 (non-static, every database), 5 (all entries, one database) and 6 (non-static, one database). With data state 0, every selected entry is invalidated. With a data state other than 0 or 0xF, the table is left unchanged.
- R8: The non-static codes select only entries with states 1 to 7. Static entries (0xE) and states 8 to 0xD are kept.
- R9: With data state 0xF, the from-port is in bits 6:4 and the to-port in bits 9:7. Each selected non-trunk entry whose port vector has the from-port bit set gets that bit cleared and the to-port bit set.
- R10: A move to port code 7 only clears the from-port bit. An entry whose port vector becomes empty is freed.
- R11: Moves leave entries with the trunk flag set unchanged.
- R12: A load of a new address into a full table is dropped, and the sixteen existing entries remain.
- R13: Operations that carry a database number in bits 3:0 only see entries stored with that number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| busy | output | 1 | Operation in progress |

## Verification
The hardest cases to reach are moves and flushes on a table that holds a mix of databases, static and non-static states and trunk entries, because only a full sweep shows that each entry was or was not touched. The bench refills the table with fourteen mixed entries before each operation. It sweeps every flush/move code against a flush, a move, a remove and a no-op data state. After each operation it walks every database with get-next and compares each returned entry with an arithmetic model. A full table, a purge and writes made while busy are set up directly.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int PORT_BITS = 3;
  localparam int NPORT     = (1 << PORT_BITS) - 1;
  localparam int DB_W      = 4;
  localparam int MAC_W     = 48;
  localparam int ST_W      = 4;
  localparam int PV_LSB    = 4;
  localparam int TRUNK_BIT = 15;

  localparam logic [ST_W-1:0] ST_FREE   = 4'h0;
  localparam logic [ST_W-1:0] ST_STATIC = 4'hE;
  localparam logic [ST_W-1:0] ST_MOVE   = 4'hF;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_FM_ALL = 3'd1,
    OP_FM_NS  = 3'd2,
    OP_LOAD   = 3'd3,
    OP_NEXT   = 3'd4,
    OP_FM_DB  = 3'd5,
    OP_FM_NSD = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef struct packed {
    logic [ST_W-1:0]  state;
    logic             trunk;
    logic [NPORT-1:0] pv;
    logic [DB_W-1:0]  db;
    logic [MAC_W-1:0] mac;
  } entry_t;

  function automatic logic is_nonstatic(input logic [ST_W-1:0] s);
    return (s != ST_FREE) && (s[3] == 1'b0);
  endfunction

  function automatic logic op_is_fm(input op_e op);
    return (op == OP_FM_ALL) || (op == OP_FM_NS) || (op == OP_FM_DB) || (op == OP_FM_NSD);
  endfunction

  function automatic logic op_ns_only(input op_e op);
    return (op == OP_FM_NS) || (op == OP_FM_NSD);
  endfunction

  function automatic logic op_per_db(input op_e op);
    return (op == OP_FM_DB) || (op == OP_FM_NSD);
  endfunction

  // Entry falls in the group a flush/move code addresses
  function automatic logic fm_selects(input entry_t e, input op_e op, input logic [DB_W-1:0] db);
    return (e.state != ST_FREE) &&
           (!op_per_db(op) || (e.db == db)) &&
           (!op_ns_only(op) || is_nonstatic(e.state));
  endfunction

  // New content of a selected entry
  function automatic entry_t fm_apply(input entry_t e, input logic [ST_W-1:0] act,
                                     input logic [PORT_BITS-1:0] from,
                                     input logic [PORT_BITS-1:0] to);
    entry_t r;
    logic [NPORT:0] ext;
    r   = e;
    ext = {1'b0, e.pv};
    if (act == ST_FREE) begin
      r.state = ST_FREE;
    end else if ((act == ST_MOVE) && !e.trunk && ext[from]) begin
      ext[from] = 1'b0;
      if (to != {PORT_BITS{1'b1}}) ext[to] = 1'b1;
      r.pv = ext[NPORT-1:0];
      if (r.pv == '0) r.state = ST_FREE;
    end
    return r;
  endfunction
endpackage

// File: rtl/atu_table.sv
module atu_table
  import atu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output entry_t           rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  output logic [DEPTH-1:0] valid_vec
);
  entry_t slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                    slot[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))       slot[g] <= wr_entry;
    end
    assign valid_vec[g] = (slot[g].state != ST_FREE);
  end

  assign rd_entry = slot[rd_idx];
endmodule

// File: rtl/atu_engine.sv
module atu_engine
  import atu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              start_op,
  input  logic [DB_W-1:0]  start_db,
  input  logic [15:0]      cfg_data,
  input  logic [MAC_W-1:0] cfg_mac,
  output logic [IDX_W-1:0] rd_idx,
  input  entry_t           rd_entry,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output entry_t           wr_entry,
  output logic             busy,
  output logic             done,
  output op_e              done_op,
  output logic             res_we,
  output entry_t           res_entry
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} st_e;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  st_e              st;
  op_e              op_q;
  logic [DB_W-1:0]  db_q;
  logic [IDX_W-1:0] idx;
  logic             best_found, hit_found, free_found;
  entry_t           best;
  logic [IDX_W-1:0] hit_idx, free_idx;

  // Named internal events
  logic   next_cand, load_match, slot_free, fm_hit;
  entry_t load_new, fm_new;

  assign rd_idx = idx;

  always_comb begin
    load_new       = '0;
    load_new.state = cfg_data[ST_W-1:0];
    load_new.trunk = cfg_data[TRUNK_BIT];
    load_new.pv    = cfg_data[PV_LSB +: NPORT];
    load_new.db    = db_q;
    load_new.mac   = cfg_mac;
  end

  assign next_cand  = (op_q == OP_NEXT) && (rd_entry.state != ST_FREE) && (rd_entry.db == db_q) &&
                      ((cfg_mac == '1) || (rd_entry.mac > cfg_mac)) &&
                      (!best_found || (rd_entry.mac < best.mac));
  assign load_match = (rd_entry.state != ST_FREE) && (rd_entry.db == db_q) && (rd_entry.mac == cfg_mac);
  assign slot_free  = (rd_entry.state == ST_FREE);
  assign fm_hit     = op_is_fm(op_q) && fm_selects(rd_entry, op_q, db_q);
  assign fm_new     = fm_apply(rd_entry, cfg_data[ST_W-1:0],
                               cfg_data[PV_LSB +: PORT_BITS],
                               cfg_data[PV_LSB + PORT_BITS +: PORT_BITS]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_NONE; db_q <= '0; idx <= '0;
      best_found <= 1'b0; best <= '0;
      hit_found <= 1'b0; hit_idx <= '0; free_found <= 1'b0; free_idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_SCAN; op_q <= start_op; db_q <= start_db; idx <= '0;
          best_found <= 1'b0; hit_found <= 1'b0; free_found <= 1'b0;
        end
        S_SCAN: begin
          if (next_cand) begin
            best_found <= 1'b1; best <= rd_entry;
          end
          if (op_q == OP_LOAD) begin
            if (load_match) begin hit_found <= 1'b1; hit_idx <= idx; end
            if (slot_free && !free_found) begin free_found <= 1'b1; free_idx <= idx; end
          end
          if (idx == LAST) st <= S_FIN;
          else             idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = idx;
    wr_entry = fm_new;
    if ((st == S_SCAN) && fm_hit) begin
      wr_en = 1'b1;
    end else if ((st == S_FIN) && (op_q == OP_LOAD)) begin
      wr_entry = load_new;
      if (hit_found) begin
        wr_en = 1'b1; wr_idx = hit_idx;
      end else if (free_found && (load_new.state != ST_FREE)) begin
        wr_en = 1'b1; wr_idx = free_idx;
      end
    end
  end

  always_comb begin
    res_entry = '0;
    if (best_found) res_entry = best;
    else            res_entry.mac = '1;
  end

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign done_op = op_q;
  assign res_we  = done && (op_q == OP_NEXT);

  // Cycle counter for the busy window check
  logic [IDX_W+1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  // R2
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt <= (IDX_W+2)'(DEPTH + 1)));
  // R2
  table_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
  // R5
  next_ascends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (res_entry.state != ST_FREE) && (cfg_mac != '1)) |-> (res_entry.mac > cfg_mac));
endmodule

// File: rtl/atu_flush_move.sv
module atu_flush_move
  import atu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy
);
  localparam logic [2:0] A_OP = 3'd0, A_DATA = 3'd1, A_MAC0 = 3'd2, A_MAC1 = 3'd3, A_MAC2 = 3'd4;

  logic [14:0]      op_q;
  logic [15:0]      data_q;
  logic [MAC_W-1:0] mac_q;

  logic             start;
  op_e              wr_op;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  entry_t           rd_entry, wr_entry, res_entry;
  logic             wr_en, done, res_we;
  op_e              done_op;
  logic [DEPTH-1:0] valid_vec;
  logic             host_wr;

  assign host_wr = reg_we && !busy;
  assign wr_op   = op_e'(reg_wdata[14:12]);
  assign start   = host_wr && (reg_addr == A_OP) && (wr_op != OP_NONE) && (wr_op != OP_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= '0; data_q <= '0; mac_q <= '0;
    end else if (res_we) begin
      data_q <= {res_entry.trunk, {(TRUNK_BIT-PV_LSB-NPORT){1'b0}}, res_entry.pv, res_entry.state};
      mac_q  <= res_entry.mac;
    end else if (host_wr) begin
      case (reg_addr)
        A_OP:    op_q          <= reg_wdata[14:0];
        A_DATA:  data_q        <= reg_wdata;
        A_MAC0:  mac_q[47:32]  <= reg_wdata;
        A_MAC1:  mac_q[31:16]  <= reg_wdata;
        A_MAC2:  mac_q[15:0]   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_OP:    reg_rdata = {busy, op_q};
      A_DATA:  reg_rdata = data_q;
      A_MAC0:  reg_rdata = mac_q[47:32];
      A_MAC1:  reg_rdata = mac_q[31:16];
      A_MAC2:  reg_rdata = mac_q[15:0];
      default: reg_rdata = '0;
    endcase
  end

  atu_table #(.DEPTH(DEPTH)) u_table (
    .clk, .rst_n, .rd_idx, .rd_entry, .wr_en, .wr_idx, .wr_entry, .valid_vec
  );

  atu_engine #(.DEPTH(DEPTH)) u_engine (
    .clk, .rst_n, .start, .start_op(wr_op), .start_db(reg_wdata[DB_W-1:0]),
    .cfg_data(data_q), .cfg_mac(mac_q), .rd_idx, .rd_entry, .wr_en, .wr_idx, .wr_entry,
    .busy, .done, .done_op, .res_we, .res_entry
  );

  // R2
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && busy && !res_we) |=> ($stable(data_q) && $stable(mac_q) && $stable(op_q)));
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_op == OP_FM_ALL) && (data_q[ST_W-1:0] == ST_FREE)) |-> (valid_vec == '0));
endmodule

// File: tb/tb_atu_flush_move.sv
module tb_atu_flush_move;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy;

  always #2.5 clk = ~clk;

  atu_flush_move #(.DEPTH(DEPTH)) dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // Reference model of the table contents
  bit          mv [DEPTH];
  logic [47:0] mmac [DEPTH];
  logic [3:0]  mdb [DEPTH];
  logic [3:0]  mst [DEPTH];
  bit          mtr [DEPTH];
  logic [6:0]  mpv [DEPTH];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    int n = 0;
    rd(3'd0, d);
    while (d[15] && n < 64) begin n++; rd(3'd0, d); end
    chk("R2 busy window", 64'(n <= DEPTH + 3), 64'd1);
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd2, m[47:32]); wr(3'd3, m[31:16]); wr(3'd4, m[15:0]);
  endtask

  task automatic run_op(input int code, input logic [3:0] db);
    wr(3'd0, 16'((code << 12) | db));
    wait_idle();
  endtask

  task automatic model_clear();
    for (int j = 0; j < DEPTH; j++) mv[j] = 0;
  endtask

  task automatic load(input logic [47:0] m, input logic [3:0] db, input logic [3:0] st,
                      input bit tr, input logic [6:0] pv);
    int hit = -1, fr = -1;
    set_mac(m);
    wr(3'd1, {tr, 4'b0, pv, st});
    run_op(3, db);
    for (int j = 0; j < DEPTH; j++) begin
      if (mv[j] && mmac[j] == m && mdb[j] == db) hit = j;
      if (!mv[j] && fr < 0) fr = j;
    end
    if (hit >= 0) begin
      if (st == 0) mv[hit] = 0;
      else begin mst[hit] = st; mtr[hit] = tr; mpv[hit] = pv; end
    end else if (st != 0 && fr >= 0) begin
      mv[fr] = 1; mmac[fr] = m; mdb[fr] = db; mst[fr] = st; mtr[fr] = tr; mpv[fr] = pv;
    end
  endtask

  // Walk one database in ascending order, comparing against the model
  task automatic walk(input string req, input logic [3:0] db);
    logic [47:0] cur = '1;
    logic [15:0] d, m0, m1, m2;
    set_mac('1);
    for (int step = 0; step <= DEPTH; step++) begin
      int best = -1;
      for (int j = 0; j < DEPTH; j++)
        if (mv[j] && mdb[j] == db && (cur == '1 || mmac[j] > cur) &&
            (best < 0 || mmac[j] < mmac[best])) best = j;
      run_op(4, db);
      rd(3'd1, d); rd(3'd2, m0); rd(3'd3, m1); rd(3'd4, m2);
      if (best < 0) begin
        chk({req, " end of db"}, {d[3:0], m0, m1, m2}, {4'h0, 48'hFFFF_FFFF_FFFF});
        break;
      end
      chk(req, {d, m0, m1, m2}, {mtr[best], 4'b0, mpv[best], mst[best], mmac[best]});
      if (d[3:0] == 0) break;
      cur = mmac[best];
    end
  endtask

  task automatic model_fm(input int code, input logic [3:0] tdb, input logic [15:0] data);
    bit ns = (code == 2 || code == 6);
    bit pd = (code == 5 || code == 6);
    int from = data[6:4], to = data[9:7];
    for (int j = 0; j < DEPTH; j++) begin
      if (!mv[j]) continue;
      if (pd && mdb[j] != tdb) continue;
      if (ns && !(mst[j] >= 1 && mst[j] <= 7)) continue;
      if (data[3:0] == 4'h0) mv[j] = 0;
      else if (data[3:0] == 4'hF && !mtr[j] && from < 7 && mpv[j][from]) begin
        mpv[j][from] = 1'b0;
        if (to != 7) mpv[j][to] = 1'b1;
        if (mpv[j] == 0) mv[j] = 0;
      end
    end
  endtask

  task automatic populate();
    logic [3:0] stl [5] = '{4'h1, 4'h7, 4'hE, 4'h8, 4'h3};
    for (int i = 0; i < 14; i++)
      load({16'h0200, 8'((i * 11) % 16), 16'h0, 8'(i)}, 4'(i % 3), stl[i % 5],
           (i % 4) == 3, 7'(((i * 37) % 127) + 1));
  endtask

  task automatic clear_all();
    wr(3'd1, 16'h0000);
    run_op(1, 4'd0);
    model_clear();
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();

    // R1 reset state
    rd(3'd0, d); chk("R1 busy after reset", 64'(d), 64'h0);
    rd(3'd1, d); chk("R1 data after reset", 64'(d), 64'h0);
    rd(3'd3, d); chk("R1 mac after reset", 64'(d), 64'h0);
    walk("R1 empty table", 4'd0);

    // R2 unused codes do not start
    wr(3'd0, 16'h7000); rd(3'd0, d); chk("R2 code 7 no busy", 64'(d[15]), 64'h0);
    wr(3'd0, 16'h0003); rd(3'd0, d); chk("R2 code 0 no busy", 64'(d[15]), 64'h0);

    // R2 writes while busy are ignored
    wr(3'd0, 16'h4002);
    rd(3'd0, d); chk("R2 busy raised", 64'(d[15]), 64'h1);
    wr(3'd1, 16'h1234);
    wr(3'd0, 16'h3005);
    wait_idle();
    rd(3'd1, d); chk("R2 data write while busy ignored", 64'(d), 64'h0);
    rd(3'd0, d); chk("R2 op word readback", 64'(d[14:0]), 64'h4002);

    // R3 readback and byte significance
    set_mac(48'h0102_0304_0506); wr(3'd1, 16'h8453);
    rd(3'd2, d); chk("R3 mac bytes 0-1", 64'(d), 64'h0102);
    rd(3'd4, d); chk("R3 mac bytes 4-5", 64'(d), 64'h0506);
    rd(3'd1, d); chk("R3 data readback", 64'(d), 64'h8453);
    load(48'h0100_0000_0000, 4'd9, 4'h2, 1'b0, 7'h01);
    load(48'h0000_0000_00FF, 4'd9, 4'h2, 1'b0, 7'h02);
    walk("R3 byte 0 most significant", 4'd9);

    // R4 overwrite and purge; R6 wrap from all ones
    load(48'h0000_0000_00FF, 4'd9, 4'h5, 1'b1, 7'h44);
    walk("R4 overwrite", 4'd9);
    load(48'h0100_0000_0000, 4'd9, 4'h0, 1'b0, 7'h00);
    walk("R4 purge", 4'd9);
    walk("R6 wrap", 4'd8);

    // R12 full table
    clear_all();
    for (int k = 0; k < DEPTH; k++) load(48'(k * 3 + 7), 4'd4, 4'h2, 1'b0, 7'(k + 1));
    load(48'h0000_0000_0001, 4'd4, 4'h2, 1'b0, 7'h7F);
    walk("R12 full table drop", 4'd4);

    // Sweep: R7 R8 R9 R10 R11 R13 over every flush/move code and action
    for (int ci = 0; ci < 4; ci++) begin
      int code = (ci < 2) ? ci + 1 : ci + 3;
      for (int kind = 0; kind < 4; kind++) begin
        int f = (code + kind) % 7;
        int t = (code * 3 + kind) % 7;
        logic [15:0] dat;
        case (kind)
          0: dat = 16'h0000;
          1: dat = 16'((t << 7) | (f << 4) | 4'hF);
          2: dat = 16'((7 << 7) | (f << 4) | 4'hF);
          default: dat = 16'h0005;
        endcase
        clear_all();
        populate();
        wr(3'd1, dat);
        run_op(code, 4'd1);
        model_fm(code, 4'd1, dat);
        for (int db = 0; db < 4; db++) begin
          case (kind)
            0: walk((code == 2 || code == 6) ? "R8 non-static flush" : "R7 flush", 4'(db));
            1: walk((db == 1) ? "R9 R11 move" : "R13 move db scope", 4'(db));
            2: walk("R10 remove", 4'(db));
            default: walk("R7 no-op state", 4'(db));
          endcase
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule